// File: doc/BRIEF.md
# Reduced-Complexity Wallace Tree Multiplier

This block multiplies two unsigned 8-bit operands and returns their full 16-bit product in the same cycle. It has no clock and holds no state. It is built as explicit logic and does not use a multiply operator. Every multiplier bit is ANDed with the multiplicand to form a pyramid of partial-product bits. These bits are then compressed in carry-save fashion over four levels.

At each level the bits of a column are taken three at a time into full adders. Each full adder keeps its sum in the same column and moves its carry one column up. A bit left alone is forwarded to the next level untouched. Two leftover bits are also forwarded, unless doing so would make the column taller than the row count the level must reach. Only in that case are they merged by a half adder. The row count therefore goes 8, 6, 4, 3, 2. A ripple carry-propagate adder then adds the last two rows.

The reduction schedule is derived from the operand width when the design is elaborated. This includes the column heights, the full-adder count of each column, and the columns where a half adder is required. The operand width is a parameter.

Top module: `rcw_mult`

## Requirements
- R1: `product_o` equals the unsigned product of `mcand_i` and `mplier_i` for every one of the 65536 operand pairs.
- R2: Product bit 0 equals `mcand_i[0] AND mplier_i[0]`, because column 0 holds a single partial-product bit.
- R3: When either operand is zero, the product is zero, whatever the other operand is.
- R4: When one operand is 1, the product equals the other operand zero-extended to 16 bits.
- R5: The largest operands, 255 × 255, give 65025 (0xFE01) with bit 15 set, and the final adder never produces a carry beyond bit 15.
- R6: 11001110 times 11010011 gives 1010100111001010.
- R7: The block is combinational: a new operand pair is reflected at `product_o` before the next clock edge, with no register in the path.
- R8: Multiplying by 2^k for k from 0 to 7 returns the other operand shifted left by k bit positions.
- R9: Alternating bit patterns (0xAA, 0x55) and all-ones against single-bit operands give the exact product. These cases drive carries through every column of every level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mcand_i | input | 8 | Multiplicand, unsigned |
| mplier_i | input | 8 | Multiplier, unsigned; bit i selects partial-product row i |
| product_o | output | 16 | Unsigned product |

## Verification
The bench aims at the columns where the reduction is thinnest or most crowded.

- **Column 0 and bit 15.** A mis-wired lone bit would corrupt the least significant bit. A lost carry from the top column would clear bit 15, which shows up at 255 × 255.
- **Half-adder columns.** A wrong merge decision would double-count or drop one weight in the middle bits. Single-bit and alternating operand patterns expose this, since the product would then differ from the shifted operand or the exact pattern value.
- **Full operand space.** An exhaustive sweep against a shift-and-add reference catches any slot swapped between levels, because every bit position sees every carry pattern.

// File: rtl/rcw_pkg.sv
package rcw_pkg;

  localparam int HBITS  = 8;
  localparam int MAXCOL = 64;

  // Column heights: HBITS bits per column, column 0 in the low slice.
  typedef logic [MAXCOL*HBITS-1:0] hvec_t;

  function automatic int hget(hvec_t v, int c);
    if (c < 0 || c >= MAXCOL) return 0;
    return int'(v[c*HBITS +: HBITS]);
  endfunction

  function automatic hvec_t hset(hvec_t v, int c, int h);
    hvec_t r;
    r = v;
    r[c*HBITS +: HBITS] = HBITS'(h);
    return r;
  endfunction

  // Heights of the partial-product pyramid of a w x w multiply.
  function automatic hvec_t pp_heights(int w);
    hvec_t v;
    v = '0;
    for (int c = 0; c < 2*w; c++) begin
      if (c < w) v = hset(v, c, c + 1);
      else       v = hset(v, c, 2*w - 1 - c);
    end
    return v;
  endfunction

  function automatic int max_height(hvec_t v, int ncol);
    int m;
    m = 0;
    for (int c = 0; c < ncol; c++)
      if (hget(v, c) > m) m = hget(v, c);
    return m;
  endfunction

  // Rows left after one pass that groups rows in threes.
  function automatic int next_target(int rows);
    return 2*(rows/3) + rows%3;
  endfunction

  // 1 when column c needs a half adder to stay within target t.
  function automatic int col_ha(hvec_t v, int t, int c);
    int cin, ha, h, fa, rem;
    cin = 0;
    ha  = 0;
    for (int k = 0; k <= c; k++) begin
      h   = hget(v, k);
      fa  = h / 3;
      rem = h % 3;
      ha  = ((rem == 2) && (fa + rem + cin > t)) ? 1 : 0;
      if (k < c) cin = fa + ha;
    end
    return ha;
  endfunction

  function automatic int col_cin(hvec_t v, int t, int c);
    if (c == 0) return 0;
    return hget(v, c-1)/3 + col_ha(v, t, c-1);
  endfunction

  // Slots at the bottom of an output column taken by forwarded bits or an HA sum.
  function automatic int col_np(hvec_t v, int t, int c);
    if (col_ha(v, t, c) != 0) return 1;
    return hget(v, c) % 3;
  endfunction

  function automatic hvec_t next_heights(hvec_t v, int t, int ncol);
    hvec_t r;
    r = '0;
    for (int c = 0; c < ncol; c++)
      r = hset(r, c, col_np(v, t, c) + hget(v, c)/3 + col_cin(v, t, c));
    return r;
  endfunction

  function automatic hvec_t level_heights(int w, int lvl);
    hvec_t v;
    v = pp_heights(w);
    for (int l = 0; l < lvl; l++)
      v = next_heights(v, next_target(max_height(v, 2*w)), 2*w);
    return v;
  endfunction

  function automatic int num_levels(int w);
    hvec_t v;
    int n;
    v = pp_heights(w);
    n = 0;
    while (max_height(v, 2*w) > 2 && n < 32) begin
      v = next_heights(v, next_target(max_height(v, 2*w)), 2*w);
      n++;
    end
    return n;
  endfunction

  function automatic int col_offset(hvec_t v, int c);
    int s;
    s = 0;
    for (int k = 0; k < c; k++) s += hget(v, k);
    return s;
  endfunction

  function automatic int total_bits(hvec_t v, int ncol);
    return col_offset(v, ncol);
  endfunction

  // Bit arithmetic of the counter cells.
  function automatic logic fa_sum(logic x, logic y, logic z);
    return x ^ y ^ z;
  endfunction

  function automatic logic fa_carry(logic x, logic y, logic z);
    return (x & y) | (z & (x ^ y));
  endfunction

  function automatic logic ha_sum(logic x, logic y);
    return x ^ y;
  endfunction

  function automatic logic ha_carry(logic x, logic y);
    return x & y;
  endfunction

endpackage

// File: rtl/rcw_fa.sv
module rcw_fa (
  input  logic x_i,
  input  logic y_i,
  input  logic z_i,
  output logic s_o,
  output logic c_o
);
  assign s_o = rcw_pkg::fa_sum(x_i, y_i, z_i);
  assign c_o = rcw_pkg::fa_carry(x_i, y_i, z_i);
endmodule

// File: rtl/rcw_ha.sv
module rcw_ha (
  input  logic x_i,
  input  logic y_i,
  output logic s_o,
  output logic c_o
);
  assign s_o = rcw_pkg::ha_sum(x_i, y_i);
  assign c_o = rcw_pkg::ha_carry(x_i, y_i);
endmodule

// File: rtl/rcw_ppgen.sv
// Partial-product bits packed column by column; within a column, rows ascend.
module rcw_ppgen import rcw_pkg::*; #(
  parameter int W = 8,
  localparam int COLS = 2*W,
  localparam hvec_t PH = pp_heights(W),
  localparam int NPP = total_bits(PH, COLS)
) (
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic [NPP-1:0] pp_o
);
  generate
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int H    = hget(PH, c);
      localparam int OFF  = col_offset(PH, c);
      localparam int ROW0 = (c > W-1) ? c - (W-1) : 0;
      for (genvar s = 0; s < H; s++) begin : g_bit
        assign pp_o[OFF+s] = mplier_i[ROW0+s] & mcand_i[c-ROW0-s];
      end
    end
  endgenerate
endmodule

// File: rtl/rcw_level.sv
// One reduction level. Output column layout, bottom up:
//   forwarded bits or HA sum | FA sums | FA carries from below | HA carry from below
module rcw_level import rcw_pkg::*; #(
  parameter int    COLS = 16,
  parameter hvec_t IN_H = pp_heights(8),
  parameter int    TGT  = next_target(max_height(pp_heights(8), 16)),
  localparam int    NIN   = total_bits(IN_H, COLS),
  localparam hvec_t OUT_H = next_heights(IN_H, TGT, COLS),
  localparam int    NOUT  = total_bits(OUT_H, COLS)
) (
  input  logic [NIN-1:0]  in_bits,
  output logic [NOUT-1:0] out_bits
);
  generate
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int H      = hget(IN_H, c);
      localparam int N_FA   = H / 3;
      localparam int N_REM  = H % 3;
      localparam int USE_HA = col_ha(IN_H, TGT, c);
      localparam int NP     = col_np(IN_H, TGT, c);
      localparam int IOFF   = col_offset(IN_H, c);
      localparam int OOFF   = col_offset(OUT_H, c);
      localparam int CSLOT  = (c+1 < COLS) ?
        col_offset(OUT_H, c+1) + col_np(IN_H, TGT, c+1) + hget(IN_H, c+1)/3 : 0;

      for (genvar k = 0; k < N_FA; k++) begin : g_fa
        if (c+1 < COLS) begin : g_in
          rcw_fa u_fa (
            .x_i(in_bits[IOFF+3*k]), .y_i(in_bits[IOFF+3*k+1]), .z_i(in_bits[IOFF+3*k+2]),
            .s_o(out_bits[OOFF+NP+k]), .c_o(out_bits[CSLOT+k]));
        end else begin : g_top
          logic drop;
          rcw_fa u_fa (
            .x_i(in_bits[IOFF+3*k]), .y_i(in_bits[IOFF+3*k+1]), .z_i(in_bits[IOFF+3*k+2]),
            .s_o(out_bits[OOFF+NP+k]), .c_o(drop));
        end
      end

      if (USE_HA != 0) begin : g_ha
        if (c+1 < COLS) begin : g_in
          rcw_ha u_ha (
            .x_i(in_bits[IOFF+3*N_FA]), .y_i(in_bits[IOFF+3*N_FA+1]),
            .s_o(out_bits[OOFF]), .c_o(out_bits[CSLOT+N_FA]));
        end else begin : g_top
          logic drop;
          rcw_ha u_ha (
            .x_i(in_bits[IOFF+3*N_FA]), .y_i(in_bits[IOFF+3*N_FA+1]),
            .s_o(out_bits[OOFF]), .c_o(drop));
        end
      end else begin : g_pass
        for (genvar s = 0; s < N_REM; s++) begin : g_bit
          assign out_bits[OOFF+s] = in_bits[IOFF+3*N_FA+s];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/rcw_cpa.sv
// Ripple carry-propagate adder over the last two rows.
module rcw_cpa import rcw_pkg::*; #(
  parameter int    COLS = 16,
  parameter hvec_t IN_H = level_heights(8, num_levels(8)),
  localparam int   NIN  = total_bits(IN_H, COLS)
) (
  input  logic [NIN-1:0]  in_bits,
  output logic [COLS-1:0] sum_o,
  output logic            cout_o
);
  logic [COLS-1:0] opx, opy;
  logic [COLS:0]   cy;

  assign cy[0] = 1'b0;

  generate
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int H   = hget(IN_H, c);
      localparam int OFF = col_offset(IN_H, c);
      if (H >= 1) begin : g_x
        assign opx[c] = in_bits[OFF];
      end else begin : g_x0
        assign opx[c] = 1'b0;
      end
      if (H >= 2) begin : g_y
        assign opy[c] = in_bits[OFF+1];
      end else begin : g_y0
        assign opy[c] = 1'b0;
      end
      rcw_fa u_cell (.x_i(opx[c]), .y_i(opy[c]), .z_i(cy[c]), .s_o(sum_o[c]), .c_o(cy[c+1]));
    end
  endgenerate

  assign cout_o = cy[COLS];
endmodule

// File: rtl/rcw_mult.sv
module rcw_mult import rcw_pkg::*; #(
  parameter int W = 8
) (
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic [2*W-1:0] product_o
);
  localparam int    COLS = 2*W;
  localparam int    NLV  = num_levels(W);
  localparam hvec_t PH   = pp_heights(W);
  localparam int    NPP  = total_bits(PH, COLS);
  localparam hvec_t HF   = level_heights(W, NLV);
  localparam int    NF   = total_bits(HF, COLS);

  logic [NPP-1:0] pp_bits;
  logic [NF-1:0]  fin_bits;
  logic           cpa_cout;   // carry out of the final adder, watched by the checker

  rcw_ppgen #(.W(W)) u_pp (.mcand_i(mcand_i), .mplier_i(mplier_i), .pp_o(pp_bits));

  generate
    for (genvar L = 0; L < NLV; L++) begin : lv
      localparam hvec_t HI = level_heights(W, L);
      localparam int    T  = next_target(max_height(HI, COLS));
      localparam int    NI = total_bits(HI, COLS);
      localparam int    NO = total_bits(next_heights(HI, T, COLS), COLS);
      logic [NI-1:0] ibits;
      logic [NO-1:0] obits;
      if (L == 0) begin : g_src
        assign ibits = pp_bits;
      end else begin : g_chain
        assign ibits = lv[L-1].obits;
      end
      rcw_level #(.COLS(COLS), .IN_H(HI), .TGT(T)) u_lvl (.in_bits(ibits), .out_bits(obits));
    end

    if (NLV == 0) begin : g_nored
      assign fin_bits = pp_bits;
    end else begin : g_red
      assign fin_bits = lv[NLV-1].obits;
    end
  endgenerate

  rcw_cpa #(.COLS(COLS), .IN_H(HF)) u_cpa (.in_bits(fin_bits), .sum_o(product_o), .cout_o(cpa_cout));
endmodule

// File: rtl/rcw_mult_chk.sv
module rcw_mult_chk #(
  parameter int W = 8
) (
  input logic [W-1:0]   a,
  input logic [W-1:0]   b,
  input logic [2*W-1:0] p,
  input logic           cout
);
  always_comb begin
    if (!$isunknown({a, b, p, cout})) begin
      // R1
      prod_match_chk: assert (p == ((2*W)'(a) * (2*W)'(b)))
        else $error("R1 product %0d for %0d x %0d", p, a, b);
      // R2
      lsb_and_chk: assert (p[0] == (a[0] & b[0]))
        else $error("R2 bit0 wrong");
      // R3
      zero_operand_chk: assert (!((a == '0) || (b == '0)) || (p == '0))
        else $error("R3 nonzero product with zero operand");
      // R4
      unit_operand_chk: assert (!(b == W'(1)) || (p == (2*W)'(a)))
        else $error("R4 x1 product wrong");
      // R5
      no_overflow_chk: assert (!cout)
        else $error("R5 final adder carried out");
    end
  end
endmodule

bind rcw_mult rcw_mult_chk #(.W(W)) u_chk (
  .a(mcand_i), .b(mplier_i), .p(product_o), .cout(cpa_cout)
);

// File: tb/rcw_mult_tb.sv
module rcw_mult_tb;
  logic        clk = 1'b0;
  logic [7:0]  a = '0;
  logic [7:0]  b = '0;
  logic [15:0] p;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  int unsigned exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;   // 125 MHz

  rcw_mult u_dut (.mcand_i(a), .mplier_i(b), .product_o(p));

  // Shift-and-add reference.
  function automatic int unsigned ref_mul(int unsigned x, int unsigned y);
    int unsigned acc = 0;
    for (int i = 0; i < 8; i++)
      if (y[i]) acc += x << i;
    return acc;
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] expv);
    n_chk++;
    if (got !== expv) begin
      n_fail++;
      $display("FAIL %s: a=%0d b=%0d got %0d (0x%04h) expected %0d (0x%04h)",
               tag, a, b, got, got, expv, expv);
    end
  endtask

  task automatic apply(input logic [7:0] x, input logic [7:0] y, input string tag,
                       input int unsigned expv);
    @(negedge clk);
    a = x;
    b = y;
    exp_q.push_back(expv);
    tag_q.push_back(tag);
  endtask

  // Compare against the model once per clock.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      int unsigned e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, p, e[15:0]);
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    finish_run();
  end

  initial begin
    // R3: idle state with both operands zero
    apply(8'd0, 8'd0, "R3 reset/zero", 0);
    // R6
    apply(8'b11001110, 8'b11010011, "R6", 16'b1010100111001010);
    // R5
    apply(8'hFF, 8'hFF, "R5 max", 16'hFE01);
    // R3
    apply(8'hFF, 8'h00, "R3", 0);
    apply(8'h00, 8'hA7, "R3", 0);
    // R4
    apply(8'hC3, 8'h01, "R4", 32'h00C3);
    apply(8'h01, 8'h5E, "R4", 32'h005E);
    // R2
    apply(8'h01, 8'h01, "R2", 1);
    apply(8'h81, 8'hFF, "R2", 129*255);
    apply(8'hFE, 8'hFF, "R2", 254*255);
    // R8
    for (int k = 0; k < 8; k++) begin
      apply(8'hB7, 8'(1 << k), "R8", 32'hB7 << k);
      apply(8'(1 << k), 8'hFF, "R8", 32'hFF << k);
    end
    // R9
    apply(8'hAA, 8'h55, "R9", 14450);
    apply(8'h55, 8'hAA, "R9", 14450);
    apply(8'hAA, 8'hAA, "R9", 28900);
    apply(8'h55, 8'h55, "R9", 7225);
    // R1: whole operand space
    for (int i = 0; i < 256; i++)
      for (int j = 0; j < 256; j++)
        apply(8'(i), 8'(j), "R1", ref_mul(i, j));
    repeat (2) @(posedge clk);
    #2;
    // R7: product settles within the cycle the operands change
    @(negedge clk);
    a = 8'd99;
    b = 8'd201;
    #1;
    check("R7", p, 16'(99*201));
    a = 8'd200;
    #1;
    check("R7", p, 16'(200*201));
    finish_run();
  end
endmodule